// File: doc/BRIEF.md
# Prescaled Up/Down General Timer

A general-purpose count engine that runs on the fast system clock. A programmable divider slows the clock to a count rate of the clock divided by (divide field + 1). The count register then steps up or down once per divided tick. When the count reaches its terminal value, a sticky event flag is set, and an interrupt request is raised if it is enabled. The terminal value is zero when counting down and the preload value when counting up. After the terminal event, the counter either restarts on its own or stops by clearing its start bit.

Software reaches the block through a simple word-addressed register port. The port has one write strobe, and a read path that is a combinational function of the address. The control word holds the counting mode, a self-clearing soft reset, a self-clearing forced reload, a halt and the divide field. One common setting counts up with auto-restart and an all-ones preload. In that setting the counter wraps freely and serves as a monotonic time base, for example a microsecond clock when a 48 MHz system clock is divided by 48.

Top module: `gpt_timer`

## Requirements
- R1: After reset, every register reads zero and `irq` is low.
- R2: The register offsets are: count 0x00, preload 0x04, event status 0x08, interrupt enable 0x0C and control 0x10. Any other address reads zero. The control fields are: bit 0 active, bit 2 count up, bit 3 auto-restart, bit 4 soft reset, bit 5 start, bit 6 reload, bit 7 halt, and bits 31:16 divide. Bits 1, 6 and 15:8 of control read zero.
- R3: While active=1, start=1 and halt=0, the counter steps by one every divide+1 clocks. The first step lands divide+1 clocks after the write that starts it.
- R4: When counting down, a step taken while the count is zero is the terminal event. It sets status bit 0.
- R5: When counting up, a step taken while the count equals the preload is the terminal event. It sets status bit 0. Without auto-restart, a terminal event (in either direction) clears start and the count holds.
- R6: With auto-restart, the terminal event reloads the count and counting continues. The count reloads to the preload value when counting down and to zero when counting up. With an all-ones preload, counting up wraps freely from all ones to zero.
- R7: A control write with bit 6 set copies the preload into the count on that same clock edge. Bit 6 is never stored.
- R8: A control write with bit 4 set returns every register to its reset value on that edge. Control bit 4 then reads 1 for exactly one clock and reads 0 afterwards.
- R9: Writing 1 to bit 0 of the event status clears it. Writing 0 has no effect.
- R10: `irq` is high exactly when event status bit 0 and interrupt enable bit 0 are both 1.
- R11: While halt=1, both the count and the divider phase hold their values. Counting resumes from the held phase when halt is cleared.
- R12: While active=0 or start=0, the count does not change.
- R13: A write to offset 0x00 loads the written value into the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_en | input | 1 | Register access strobe |
| bus_we | input | 1 | Write when high, read when low |
| bus_addr | input | AW (5) | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| irq | output | 1 | Interrupt request |

## Verification
The hardest situation to reach from the ports is a halt that lands while the divider is partway through its period. Only the count is visible, so a divider that was cleared instead of held looks the same until the next step comes late. The stimulus starts a divide-by-four down count and applies halt after six clocks, which leaves the phase one clock short of a tick. It then releases halt and expects the next step exactly one clock later. A table of mode, preload and wait-length vectors covers the terminal events in both directions, with and without restart, including the all-ones wrap.

// File: rtl/gpt_pkg.sv
package gpt_pkg;

   localparam int unsigned GPT_DW = 32;

   // register byte offsets
   localparam int unsigned OFS_COUNT   = 0;
   localparam int unsigned OFS_PRELOAD = 4;
   localparam int unsigned OFS_STATUS  = 8;
   localparam int unsigned OFS_INTEN   = 12;
   localparam int unsigned OFS_CONTROL = 16;

   // control word bit positions
   localparam int unsigned CB_ACT    = 0;
   localparam int unsigned CB_UP     = 2;
   localparam int unsigned CB_ARST   = 3;
   localparam int unsigned CB_SRST   = 4;
   localparam int unsigned CB_START  = 5;
   localparam int unsigned CB_RELOAD = 6;
   localparam int unsigned CB_HALT   = 7;
   localparam int unsigned CB_DIV    = 16;
   localparam int unsigned DIV_MAX_W = 16;

   typedef struct packed {
      logic halt;
      logic start;
      logic arst;
      logic up;
      logic act;
   } gpt_mode_t;

   typedef enum logic [2:0] {
      SEL_NONE,
      SEL_COUNT,
      SEL_PRELOAD,
      SEL_STATUS,
      SEL_INTEN,
      SEL_CONTROL
   } gpt_sel_e;

endpackage

// File: rtl/gpt_addr_dec.sv
module gpt_addr_dec
   import gpt_pkg::*;
#(
   parameter int unsigned AW = 5
) (
   input  logic [AW-1:0] addr,
   output gpt_sel_e      sel
);

   always_comb begin
      if (addr == AW'(OFS_COUNT))        sel = SEL_COUNT;
      else if (addr == AW'(OFS_PRELOAD)) sel = SEL_PRELOAD;
      else if (addr == AW'(OFS_STATUS))  sel = SEL_STATUS;
      else if (addr == AW'(OFS_INTEN))   sel = SEL_INTEN;
      else if (addr == AW'(OFS_CONTROL)) sel = SEL_CONTROL;
      else                               sel = SEL_NONE;
   end

endmodule

// File: rtl/gpt_prescaler.sv
module gpt_prescaler #(
   parameter int unsigned PRE_W = 16,
   localparam int unsigned PSC_W = (PRE_W > 0) ? PRE_W : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,    // restart the phase
   input  logic             en,     // active and started
   input  logic             hold,   // halt: freeze phase
   input  logic [PSC_W-1:0] div,
   output logic             tick
);

   generate
      if (PRE_W > 0) begin : g_div
         logic [PSC_W-1:0] phase_q;
         logic             wrap;

         assign wrap = (phase_q == div);
         assign tick = en && !hold && wrap;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               phase_q <= '0;
            end else if (clr || !en) begin
               phase_q <= '0;
            end else if (!hold) begin
               phase_q <= wrap ? '0 : phase_q + PSC_W'(1);
            end
         end
      end else begin : g_pass
         logic unused_pass;
         assign unused_pass = ^{clk, rst_n, clr, div};
         assign tick = en && !hold;
      end
   endgenerate

endmodule

// File: rtl/gpt_counter.sv
module gpt_counter #(
   parameter int unsigned CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             up,
   input  logic             arst,
   input  logic [CNT_W-1:0] preload,
   input  logic             ld,
   input  logic [CNT_W-1:0] ld_val,
   output logic [CNT_W-1:0] cnt,
   output logic             term
);

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] end_val;
   logic [CNT_W-1:0] restart_val;

   assign end_val     = up ? preload : '0;
   assign restart_val = up ? '0 : preload;
   assign term        = tick && (cnt_q == end_val);
   assign cnt         = cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (ld) begin
         cnt_q <= ld_val;
      end else if (term) begin
         if (arst) cnt_q <= restart_val;
      end else if (tick) begin
         cnt_q <= up ? cnt_q + CNT_W'(1) : cnt_q - CNT_W'(1);
      end
   end

endmodule

// File: rtl/gpt_regs.sv
module gpt_regs
   import gpt_pkg::*;
#(
   parameter int unsigned CNT_W = 32,
   parameter int unsigned PRE_W = 16,
   localparam int unsigned PSC_W = (PRE_W > 0) ? PRE_W : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  gpt_sel_e          sel,
   input  logic [GPT_DW-1:0] wdata,
   input  logic [CNT_W-1:0]  cnt,
   input  logic              term,
   output logic [CNT_W-1:0]  preload,
   output gpt_mode_t         mode,
   output logic [PSC_W-1:0]  div,
   output logic              ie,
   output logic              status,
   output logic              srst_flag,
   output logic              cnt_ld,
   output logic [CNT_W-1:0]  cnt_ld_val,
   output logic [GPT_DW-1:0] rdata
);

   logic             wr_ctrl, wr_cnt, wr_pre, wr_ie, wr_st;
   logic             sw_srst, sw_rld;
   logic [PSC_W-1:0] div_wval;
   logic [CNT_W-1:0] preload_q;
   gpt_mode_t        mode_q;
   logic [PSC_W-1:0] div_q;
   logic             ie_q, status_q, srst_q;
   logic             unused_wdata;

   assign unused_wdata = ^wdata;

   assign wr_ctrl = wr_en && (sel == SEL_CONTROL);
   assign wr_cnt  = wr_en && (sel == SEL_COUNT);
   assign wr_pre  = wr_en && (sel == SEL_PRELOAD);
   assign wr_ie   = wr_en && (sel == SEL_INTEN);
   assign wr_st   = wr_en && (sel == SEL_STATUS);
   assign sw_srst = wr_ctrl && wdata[CB_SRST];
   assign sw_rld  = wr_ctrl && wdata[CB_RELOAD] && !sw_srst;

   generate
      if (PRE_W > 0) begin : g_divw
         assign div_wval = wdata[CB_DIV +: PSC_W];
      end else begin : g_nodivw
         assign div_wval = '0;
      end
   endgenerate

   // counter load request: soft reset, forced reload or direct write
   assign cnt_ld = sw_srst || sw_rld || wr_cnt;
   always_comb begin
      if (sw_srst)     cnt_ld_val = '0;
      else if (sw_rld) cnt_ld_val = preload_q;
      else             cnt_ld_val = wdata[CNT_W-1:0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         preload_q <= '0;
         mode_q    <= '0;
         div_q     <= '0;
         ie_q      <= 1'b0;
         status_q  <= 1'b0;
         srst_q    <= 1'b0;
      end else if (sw_srst) begin
         preload_q <= '0;
         mode_q    <= '0;
         div_q     <= '0;
         ie_q      <= 1'b0;
         status_q  <= 1'b0;
         srst_q    <= 1'b1;
      end else begin
         srst_q <= 1'b0;
         if (wr_pre) preload_q <= wdata[CNT_W-1:0];
         if (wr_ie)  ie_q      <= wdata[0];
         if (term)                    status_q <= 1'b1;
         else if (wr_st && wdata[0])  status_q <= 1'b0;
         if (wr_ctrl) begin
            mode_q.act   <= wdata[CB_ACT];
            mode_q.up    <= wdata[CB_UP];
            mode_q.arst  <= wdata[CB_ARST];
            mode_q.start <= wdata[CB_START];
            mode_q.halt  <= wdata[CB_HALT];
            div_q        <= div_wval;
         end else if (term && !mode_q.arst) begin
            mode_q.start <= 1'b0;
         end
      end
   end

   always_comb begin
      rdata = '0;
      case (sel)
         SEL_COUNT:   rdata[CNT_W-1:0] = cnt;
         SEL_PRELOAD: rdata[CNT_W-1:0] = preload_q;
         SEL_STATUS:  rdata[0]         = status_q;
         SEL_INTEN:   rdata[0]         = ie_q;
         SEL_CONTROL: begin
            rdata[CB_ACT]          = mode_q.act;
            rdata[CB_UP]           = mode_q.up;
            rdata[CB_ARST]         = mode_q.arst;
            rdata[CB_SRST]         = srst_q;
            rdata[CB_START]        = mode_q.start;
            rdata[CB_HALT]         = mode_q.halt;
            rdata[CB_DIV +: PSC_W] = div_q;
         end
         default: rdata = '0;
      endcase
   end

   assign preload   = preload_q;
   assign mode      = mode_q;
   assign div       = div_q;
   assign ie        = ie_q;
   assign status    = status_q;
   assign srst_flag = srst_q;

endmodule

// File: rtl/gpt_timer.sv
module gpt_timer
   import gpt_pkg::*;
#(
   parameter int unsigned CNT_W = 32,
   parameter int unsigned PRE_W = 16,
   parameter int unsigned AW    = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_en,
   input  logic              bus_we,
   input  logic [AW-1:0]     bus_addr,
   input  logic [GPT_DW-1:0] bus_wdata,
   output logic [GPT_DW-1:0] bus_rdata,
   output logic              irq
);

   localparam int unsigned PSC_W = (PRE_W > 0) ? PRE_W : 1;

   generate
      if (CNT_W < 2 || CNT_W > GPT_DW) begin : g_bad_cnt
         $error("gpt_timer: CNT_W must be within 2..32");
      end
      if (PRE_W > DIV_MAX_W) begin : g_bad_pre
         $error("gpt_timer: PRE_W must not exceed 16");
      end
      if (AW < 5) begin : g_bad_aw
         $error("gpt_timer: AW must cover offset 0x10");
      end
   endgenerate

   gpt_sel_e         sel;
   gpt_mode_t        mode;
   logic [CNT_W-1:0] cnt, preload, cnt_ld_val;
   logic [PSC_W-1:0] div;
   logic             ie, status, srst_flag, cnt_ld;
   logic             tick, term, run;

   gpt_addr_dec #(.AW(AW)) u_dec (
      .addr (bus_addr),
      .sel  (sel)
   );

   gpt_regs #(.CNT_W(CNT_W), .PRE_W(PRE_W)) u_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_en      (bus_en && bus_we),
      .sel        (sel),
      .wdata      (bus_wdata),
      .cnt        (cnt),
      .term       (term),
      .preload    (preload),
      .mode       (mode),
      .div        (div),
      .ie         (ie),
      .status     (status),
      .srst_flag  (srst_flag),
      .cnt_ld     (cnt_ld),
      .cnt_ld_val (cnt_ld_val),
      .rdata      (bus_rdata)
   );

   assign run = mode.act && mode.start;

   gpt_prescaler #(.PRE_W(PRE_W)) u_psc (
      .clk  (clk),
      .rst_n(rst_n),
      .clr  (cnt_ld),
      .en   (run),
      .hold (mode.halt),
      .div  (div),
      .tick (tick)
   );

   gpt_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk    (clk),
      .rst_n  (rst_n),
      .tick   (tick),
      .up     (mode.up),
      .arst   (mode.arst),
      .preload(preload),
      .ld     (cnt_ld),
      .ld_val (cnt_ld_val),
      .cnt    (cnt),
      .term   (term)
   );

   assign irq = status && ie;

endmodule

// File: rtl/gpt_timer_chk.sv
module gpt_timer_chk
   import gpt_pkg::*;
#(
   parameter int unsigned CNT_W = 32,
   parameter int unsigned AW    = 5
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_en,
   input logic              bus_we,
   input logic [AW-1:0]     bus_addr,
   input logic [GPT_DW-1:0] bus_wdata,
   input logic [CNT_W-1:0]  cnt,
   input logic [CNT_W-1:0]  preload,
   input logic              status,
   input logic              ie,
   input logic              irq,
   input logic              term,
   input logic              tick,
   input gpt_mode_t         mode,
   input logic              srst_flag,
   input logic              cnt_ld
);

   logic ctrl_wr, stat_wr, unused_chk;

   assign ctrl_wr    = bus_en && bus_we && (bus_addr == AW'(OFS_CONTROL));
   assign stat_wr    = bus_en && bus_we && (bus_addr == AW'(OFS_STATUS));
   assign unused_chk = ^bus_wdata[GPT_DW-1:1];

   // R3: an ordinary tick moves the count by exactly one in the set direction
   p_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(tick) && !$past(term) && !$past(cnt_ld)) |->
      (cnt == ($past(mode.up) ? $past(cnt) + CNT_W'(1) : $past(cnt) - CNT_W'(1))));

   // R12: no tick and no load means the count stays put
   p_idle_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (!$past(tick) && !$past(cnt_ld)) |-> $stable(cnt));

   // R11: halted cycles leave the count unchanged
   p_halt_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(mode.halt) && !$past(cnt_ld)) |-> $stable(cnt));

   // R4: a terminal event leaves the status flag set
   p_term_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (term && !cnt_ld) |=> status);

   // R5: terminal without restart drops start
   p_stop_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (term && !mode.arst && !ctrl_wr) |=> !mode.start);

   // R8: while the soft-reset flag reads back, every register is at default
   p_srst_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
      srst_flag |-> (cnt == '0 && preload == '0 && !status && !ie && !mode.start));

   // R9: writing one to the status clears it unless a new event arrives
   p_w1c_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_wr && bus_wdata[0] && !term) |=> !status);

   // R10: the request only rises from a new event or a new enable
   p_irq_rise_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq) |-> ($past(term) || $rose(ie)));

endmodule

bind gpt_timer gpt_timer_chk #(.CNT_W(CNT_W), .AW(AW)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .bus_en   (bus_en),
   .bus_we   (bus_we),
   .bus_addr (bus_addr),
   .bus_wdata(bus_wdata),
   .cnt      (cnt),
   .preload  (preload),
   .status   (status),
   .ie       (ie),
   .irq      (irq),
   .term     (term),
   .tick     (tick),
   .mode     (mode),
   .srst_flag(srst_flag),
   .cnt_ld   (cnt_ld)
);

// File: tb/gpt_timer_test.sv
`timescale 1ns/1ps
module gpt_timer_test;

   localparam logic [4:0] A_CNT  = 5'h00;
   localparam logic [4:0] A_PRE  = 5'h04;
   localparam logic [4:0] A_STAT = 5'h08;
   localparam logic [4:0] A_IEN  = 5'h0C;
   localparam logic [4:0] A_CTRL = 5'h10;
   localparam int NVEC = 10;

   // {pad4, up, arst, div8, preload32, init32, wait16, exp_cnt32, exp_status, exp_start}
   localparam logic [127:0] VEC [NVEC] = '{
      {4'h0, 1'b0, 1'b0, 8'd0, 32'd10,         32'd10,         16'd4,  32'd6,  1'b0, 1'b1},
      {4'h0, 1'b0, 1'b0, 8'd0, 32'd3,          32'd3,          16'd10, 32'd0,  1'b1, 1'b0},
      {4'h0, 1'b0, 1'b1, 8'd0, 32'd3,          32'd3,          16'd6,  32'd1,  1'b1, 1'b1},
      {4'h0, 1'b0, 1'b0, 8'd3, 32'd100,        32'd100,        16'd20, 32'd95, 1'b0, 1'b1},
      {4'h0, 1'b1, 1'b0, 8'd0, 32'd5,          32'd0,          16'd4,  32'd4,  1'b0, 1'b1},
      {4'h0, 1'b1, 1'b0, 8'd0, 32'd5,          32'd0,          16'd9,  32'd5,  1'b1, 1'b0},
      {4'h0, 1'b1, 1'b1, 8'd1, 32'd2,          32'd0,          16'd12, 32'd0,  1'b1, 1'b1},
      {4'h0, 1'b1, 1'b1, 8'd0, 32'hFFFF_FFFF,  32'hFFFF_FFFE,  16'd3,  32'd1,  1'b1, 1'b1},
      {4'h0, 1'b0, 1'b0, 8'd4, 32'd7,          32'd7,          16'd14, 32'd5,  1'b0, 1'b1},
      {4'h0, 1'b1, 1'b1, 8'd0, 32'd0,          32'd0,          16'd3,  32'd0,  1'b1, 1'b1}
   };

   logic        clk = 1'b0;
   logic        rst_n;
   logic        bus_en, bus_we;
   logic [4:0]  bus_addr;
   logic [31:0] bus_wdata;
   logic [31:0] bus_rdata;
   logic        irq;

   int n_chk = 0;
   int n_err = 0;

   always #4 clk = ~clk;

   gpt_timer uut (
      .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
   );

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: got %h expected %h", tag, act, exp);
      end
   endtask

   task automatic bus_wr(input logic [4:0] a, input logic [31:0] d);
      bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
      @(posedge clk);
      @(negedge clk);
      bus_en = 1'b0; bus_we = 1'b0;
   endtask

   task automatic bus_rd(input logic [4:0] a, output logic [31:0] d);
      bus_addr = a;
      #1;
      d = bus_rdata;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_err++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

   initial begin
      logic [127:0] e;
      logic [31:0]  rv;
      rst_n = 1'b0; bus_en = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1: reset values
      bus_rd(A_CNT, rv);  check("R1 count", rv, 32'h0);
      bus_rd(A_PRE, rv);  check("R1 preload", rv, 32'h0);
      bus_rd(A_STAT, rv); check("R1 status", rv, 32'h0);
      bus_rd(A_IEN, rv);  check("R1 enable", rv, 32'h0);
      bus_rd(A_CTRL, rv); check("R1 control", rv, 32'h0);
      check("R1 irq", {31'h0, irq}, 32'h0);

      // R2: unmapped offset and control field readback
      bus_rd(5'h14, rv); check("R2 unmapped", rv, 32'h0);
      bus_wr(A_CTRL, 32'hABCD_FFEF);
      bus_rd(A_CTRL, rv); check("R2 control fields", rv, 32'hABCD_00AD);

      // R8: soft reset
      bus_wr(A_PRE, 32'h1234);
      bus_wr(A_IEN, 32'h1);
      bus_wr(A_CTRL, 32'h10);
      bus_rd(A_CTRL, rv); check("R8 flag visible", rv, 32'h10);
      bus_rd(A_PRE, rv);  check("R8 preload cleared", rv, 32'h0);
      bus_rd(A_IEN, rv);  check("R8 enable cleared", rv, 32'h0);
      @(negedge clk);
      bus_rd(A_CTRL, rv); check("R8 flag self-clears", rv, 32'h0);

      // R7: forced reload
      bus_wr(A_PRE, 32'h55);
      bus_wr(A_CTRL, 32'h40);
      bus_rd(A_CNT, rv);  check("R7 reload copies preload", rv, 32'h55);
      bus_rd(A_CTRL, rv); check("R7 reload bit not stored", rv, 32'h0);

      // R13: direct counter write
      bus_wr(A_CNT, 32'hDEAD_BEEF);
      bus_rd(A_CNT, rv); check("R13 count write", rv, 32'hDEAD_BEEF);

      // vector table: R3 R4 R5 R6
      for (int i = 0; i < NVEC; i++) begin
         e = VEC[i];
         bus_wr(A_CTRL, 32'h10);
         bus_wr(A_PRE, e[113:82]);
         bus_wr(A_CNT, e[81:50]);
         bus_wr(A_CTRL, {8'h00, e[121:114], 8'h00, 4'b0010, e[122], e[123], 1'b0, 1'b1});
         repeat (int'(e[49:34])) @(negedge clk);
         bus_rd(A_CNT, rv);
         check($sformatf("R3/R4/R5/R6 vec %0d count", i), rv, e[33:2]);
         bus_rd(A_STAT, rv);
         check($sformatf("R4/R5 vec %0d status", i), rv, {31'h0, e[1]});
         bus_rd(A_CTRL, rv);
         check($sformatf("R5/R6 vec %0d start", i), {31'h0, rv[5]}, {31'h0, e[0]});
      end

      // R9 / R10: status clear and interrupt gating
      bus_wr(A_CTRL, 32'h10);
      bus_wr(A_CNT, 32'd1);
      bus_wr(A_CTRL, 32'h21);
      repeat (5) @(negedge clk);
      bus_rd(A_STAT, rv); check("R4 event from one", rv, 32'h1);
      check("R10 irq masked", {31'h0, irq}, 32'h0);
      bus_wr(A_IEN, 32'h1);
      check("R10 irq enabled", {31'h0, irq}, 32'h1);
      bus_wr(A_STAT, 32'h0);
      bus_rd(A_STAT, rv); check("R9 write zero ignored", rv, 32'h1);
      bus_wr(A_STAT, 32'h1);
      bus_rd(A_STAT, rv); check("R9 write one clears", rv, 32'h0);
      check("R10 irq follows clear", {31'h0, irq}, 32'h0);

      // R11: halt mid-period holds count and divider phase
      bus_wr(A_CTRL, 32'h10);
      bus_wr(A_CNT, 32'd50);
      bus_wr(A_CTRL, 32'h0003_0021);
      repeat (6) @(negedge clk);
      bus_rd(A_CNT, rv); check("R3 divided step", rv, 32'd49);
      bus_wr(A_CTRL, 32'h0003_00A1);
      repeat (10) @(negedge clk);
      bus_rd(A_CNT, rv); check("R11 halted count", rv, 32'd49);
      bus_wr(A_CTRL, 32'h0003_0021);
      @(negedge clk);
      bus_rd(A_CNT, rv); check("R11 phase held", rv, 32'd48);

      // R12: inactive block does not count
      bus_wr(A_CTRL, 32'h10);
      bus_wr(A_CNT, 32'd20);
      bus_wr(A_CTRL, 32'h20);
      repeat (8) @(negedge clk);
      bus_rd(A_CNT, rv); check("R12 inactive hold", rv, 32'd20);
      bus_wr(A_CTRL, 32'h21);
      repeat (3) @(negedge clk);
      bus_rd(A_CNT, rv); check("R12 counts once active", rv, 32'd17);

      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

endmodule